// File: doc/BRIEF.md
# Root Port Error and PME Interrupt Control

This block holds the 16-bit control register of a PCI Express root port that decides which events interrupt the host. It takes error indications of three severities, correctable, non-fatal and fatal. Each severity can arrive as a received error message or as an error detected locally. When that severity is enabled and the port runs as the root complex, the block emits a one-cycle system-error pulse. The block also watches a power-management event (PME) status bit. It raises a one-cycle PME interrupt when that status becomes pending while the PME enable is on. It raises the same interrupt when the enable is switched on while the status is already pending.

Software reaches the register through a plain read/write port. A write takes effect at the clock edge that samples it. A read strobe returns the data on the next cycle. Only the four low bits are storage. The rest of the word reads back as zero.

Top module: `rpe_root_irq`

## Requirements
- R1: After reset the four control bits are zero, `cfg_rdata` is zero, and both interrupt outputs are low.
- R2: A write to offset 0x0EC stores `cfg_wdata[3:0]`. A read strobe at offset 0x0EC returns the stored bits in `cfg_rdata[3:0]` on the following cycle. Bit 3 is the PME enable, bit 2 is the fatal enable, bit 1 is the non-fatal enable and bit 0 is the correctable enable.
- R3: Bits 15:4 always read as zero and writes to them are ignored. A write to any other offset leaves the register unchanged. A read of any other offset returns zero.
- R4: The strobe vectors `rx_err` and `loc_err` use bit 0 for correctable, bit 1 for non-fatal and bit 2 for fatal. When `root_mode` is high and a strobe of a severity whose enable is set is present at a clock edge, `serr_pulse` is high for the cycle after that edge.
- R5: A strobe whose severity enable is clear produces no `serr_pulse`.
- R6: While `root_mode` is low, error strobes produce no `serr_pulse`. The control bits still accept writes and read back normally.
- R7: Several enabled strobes in the same cycle, received or local, give a single `serr_pulse` one cycle long.
- R8: With the PME enable set, a 0-to-1 change of `pme_status` gives `pme_irq` high for the one cycle after the edge that samples it.
- R9: When the PME enable changes from 0 to 1 while `pme_status` is already high, `pme_irq` is high for one cycle. That cycle is the second cycle after the write is sampled.
- R10: No `pme_irq` appears when the PME enable is written to 1 while already 1, when the enable rises while `pme_status` is low, or when `pme_status` rises while the enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data, valid the cycle after `cfg_rd` |
| rx_err | input | 3 | Received error message strobes by severity |
| loc_err | input | 3 | Locally detected error strobes by severity |
| pme_status | input | 1 | PME status pending |
| root_mode | input | 1 | High when the port operates as root complex |
| serr_pulse | output | 1 | System-error interrupt pulse |
| pme_irq | output | 1 | PME interrupt pulse |

## Verification
The hardest case to reach is the PME interrupt caused by the enable itself. `pme_status` must already be high while the enable is clear, and a register write must then turn the enable on. The interrupt must appear exactly two cycles after that write, and a second write of the same value must stay silent. The bench builds that sequence through the register port. For the error path it sweeps every enable pattern against every combination of received and local strobes in both operating modes.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
  localparam int SEV_N   = 3;
  localparam int SEV_COR = 0;
  localparam int SEV_NF  = 1;
  localparam int SEV_FAT = 2;

  typedef struct packed {
    logic             pme_en;
    logic [SEV_N-1:0] sev_en;
  } ctrl_t;
endpackage

// File: rtl/rpe_ctrl_reg.sv
module rpe_ctrl_reg
  import rpe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h0EC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output ctrl_t             ctrl
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic              hit;
  logic [CTRL_W-1:0] ctrl_bits;

  assign hit       = (cfg_addr == REG_OFFSET);
  assign ctrl_bits = ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_wr && hit) ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      cfg_rdata <= '0;
      if (cfg_rd && hit) cfg_rdata <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_bits};
    end
  end

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[DATA_W-1:CTRL_W] == '0);
  p_miss_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !hit) |=> $stable(ctrl));
  p_read_back_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && hit && !cfg_wr) |=> cfg_rdata[CTRL_W-1:0] == $past(ctrl_bits));
endmodule

// File: rtl/rpe_serr_gen.sv
module rpe_serr_gen #(
  parameter int SEV_N = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEV_N-1:0] rx_err,
  input  logic [SEV_N-1:0] loc_err,
  input  logic [SEV_N-1:0] sev_en,
  input  logic             root_mode,
  output logic             serr_pulse
);
  logic [SEV_N-1:0] sev_hit;

  for (genvar i = 0; i < SEV_N; i++) begin : g_sev
    assign sev_hit[i] = (rx_err[i] | loc_err[i]) & sev_en[i];
  end

  always_ff @(posedge clk) begin
    if (rst) serr_pulse <= 1'b0;
    else     serr_pulse <= root_mode & (|sev_hit);
  end

  p_serr_root_only_r6: assert property (@(posedge clk) disable iff (rst)
    !root_mode |=> !serr_pulse);
  p_serr_enabled_r5: assert property (@(posedge clk) disable iff (rst)
    ((sev_en & (rx_err | loc_err)) == '0) |=> !serr_pulse);
endmodule

// File: rtl/rpe_pme_gen.sv
module rpe_pme_gen (
  input  logic clk,
  input  logic rst,
  input  logic pme_en,
  input  logic pme_status,
  output logic pme_irq
);
  logic en_q;
  logic status_q;
  logic status_rise;
  logic en_rise;

  assign status_rise = pme_status & ~status_q;
  assign en_rise     = pme_en & ~en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      status_q <= 1'b0;
      pme_irq  <= 1'b0;
    end else begin
      en_q     <= pme_en;
      status_q <= pme_status;
      pme_irq  <= pme_en & (status_rise | (en_rise & pme_status));
    end
  end

  p_pme_cause_r8: assert property (@(posedge clk) disable iff (rst)
    pme_irq |-> $past(pme_en && pme_status));
  p_pme_single_r10: assert property (@(posedge clk) disable iff (rst)
    pme_irq |=> !pme_irq);
endmodule

// File: rtl/rpe_root_irq.sv
module rpe_root_irq
  import rpe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h0EC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [SEV_N-1:0]  rx_err,
  input  logic [SEV_N-1:0]  loc_err,
  input  logic              pme_status,
  input  logic              root_mode,
  output logic              serr_pulse,
  output logic              pme_irq
);
  ctrl_t ctrl;

  rpe_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
  ) u_reg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctrl(ctrl)
  );

  rpe_serr_gen #(.SEV_N(SEV_N)) u_serr (
    .clk(clk), .rst(rst), .rx_err(rx_err), .loc_err(loc_err),
    .sev_en(ctrl.sev_en), .root_mode(root_mode), .serr_pulse(serr_pulse)
  );

  rpe_pme_gen u_pme (
    .clk(clk), .rst(rst), .pme_en(ctrl.pme_en), .pme_status(pme_status),
    .pme_irq(pme_irq)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!serr_pulse && !pme_irq && cfg_rdata == '0));
endmodule

// File: tb/rpe_root_irq_tb.sv
`timescale 1ns/1ps
module rpe_root_irq_tb;
  localparam real CLK_P = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [2:0]  rx_err = '0, loc_err = '0;
  logic        pme_status = 1'b0, root_mode = 1'b0;
  logic        serr_pulse, pme_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rpe_root_irq u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_err(rx_err), .loc_err(loc_err),
    .pme_status(pme_status), .root_mode(root_mode), .serr_pulse(serr_pulse),
    .pme_irq(pme_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_rd = 1'b0; d = cfg_rdata;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 serr", {15'd0, serr_pulse}, 16'd0);
    check("R1 pme", {15'd0, pme_irq}, 16'd0);
    check("R1 rdata", cfg_rdata, 16'd0);
    rst = 1'b0;
    reg_read(12'h0EC, rd);
    check("R1 ctrl", rd, 16'd0);

    // R2 / R3: readback and reserved bits
    reg_write(12'h0EC, 16'hFFFF);
    reg_read(12'h0EC, rd);
    check("R3 rsvd", rd, 16'h000F);
    reg_write(12'h0E8, 16'h0000);
    reg_read(12'h0EC, rd);
    check("R3 other offset write", rd, 16'h000F);
    reg_read(12'h0F0, rd);
    check("R3 other offset read", rd, 16'h0000);

    // R4..R7: sweep enables x mode x strobes
    for (int en = 0; en < 8; en++) begin
      reg_write(12'h0EC, 16'(en));
      reg_read(12'h0EC, rd);
      check("R2 readback", rd, 16'(en));
      for (int rm = 0; rm < 2; rm++) begin
        for (int m = 0; m < 8; m++) begin
          for (int l = 0; l < 8; l++) begin
            logic exp_s;
            exp_s = (rm == 1) && (((m | l) & en) != 0);
            @(negedge clk); root_mode = rm[0]; rx_err = m[2:0]; loc_err = l[2:0];
            @(negedge clk); rx_err = '0; loc_err = '0;
            if (rm == 0) check("R6 no serr outside root mode", {15'd0, serr_pulse}, 16'd0);
            else if (exp_s) check("R4 serr on enabled severity", {15'd0, serr_pulse}, 16'd1);
            else check("R5 no serr when disabled", {15'd0, serr_pulse}, 16'd0);
            @(negedge clk);
            check("R7 single cycle pulse", {15'd0, serr_pulse}, 16'd0);
          end
        end
      end
    end
    root_mode = 1'b0;
    reg_write(12'h0EC, 16'h0005);
    reg_read(12'h0EC, rd);
    check("R6 register writable outside root mode", rd, 16'h0005);

    // R9: enable rises while status pending
    reg_write(12'h0EC, 16'h0000);
    @(negedge clk); pme_status = 1'b1;
    @(negedge clk);
    check("R10 status rise with enable clear", {15'd0, pme_irq}, 16'd0);
    reg_write(12'h0EC, 16'h0008);
    check("R9 not yet", {15'd0, pme_irq}, 16'd0);
    @(negedge clk);
    check("R9 enable rise irq", {15'd0, pme_irq}, 16'd1);
    @(negedge clk);
    check("R9 one cycle", {15'd0, pme_irq}, 16'd0);
    // R10: rewrite 1 while 1
    reg_write(12'h0EC, 16'h0008);
    @(negedge clk);
    check("R10 rewrite no irq", {15'd0, pme_irq}, 16'd0);
    @(negedge clk);
    check("R10 rewrite no irq later", {15'd0, pme_irq}, 16'd0);

    // R8: status rises with enable set
    @(negedge clk); pme_status = 1'b0;
    @(negedge clk); pme_status = 1'b1;
    @(negedge clk);
    check("R8 status rise irq", {15'd0, pme_irq}, 16'd1);
    @(negedge clk);
    check("R8 one cycle", {15'd0, pme_irq}, 16'd0);

    // R10: enable rise with status low
    pme_status = 1'b0;
    reg_write(12'h0EC, 16'h0000);
    reg_write(12'h0EC, 16'h0008);
    @(negedge clk);
    check("R10 enable rise status low", {15'd0, pme_irq}, 16'd0);
    @(negedge clk);
    check("R10 enable rise status low later", {15'd0, pme_irq}, 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule